// File: doc/BRIEF.md
# Architectural register file with byte pairs

This block holds the programmer-visible state of a small 8-bit processor core: eight byte-wide registers (accumulator, flags and six general registers), a 16-bit stack pointer and a 16-bit program counter. The six general registers and the accumulator/flags couple form four 16-bit pairs. Each pair can be read or written as a whole or one byte at a time, and both views always agree. Decode and execute logic around the block drive its write ports. Results land on the next rising clock edge. The read ports are purely combinational, so an operand can be fetched in the same cycle that it is selected.

The flags byte carries four condition bits at fixed positions. Each bit can be read on its own. Each bit can also be updated on its own, and the other bits of the flags byte keep their values. The program counter has two inputs. A direct load serves jumps. An advance input adds the length of the instruction just consumed, which is 1, 2 or 3 bytes.

Top module: `cpu_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, all eight byte registers and the stack pointer become 0x00/0x0000 and the program counter becomes 0x0100.
- R2: Byte register index encoding is 0=accumulator, 1=flags, 2..7 = the general registers in pair order (2 high/3 low, 4 high/5 low, 6 high/7 low). A byte write lands on the next rising edge. The byte read port shows the old value until that edge and the new value after it.
- R3: Pair index p (0..3) reads as {byte[2p], byte[2p+1]}: the even index is the high byte. For example, accumulator 0x55 with flags 0xFF reads pair 0 as 0x55FF.
- R4: A pair write of a 16-bit value stores bits 15:8 in byte 2p and bits 7:0 in byte 2p+1 on the next edge.
- R5: When a byte write and a pair write hit the same byte in one cycle, the byte write wins for that byte. The other byte of the pair still takes its half of the pair data.
- R6: Flag select 0, 1, 2 and 3 read bits 7 (zero), 6 (subtract), 5 (half-carry) and 4 (carry) of the flags byte.
- R7: A single-flag update writes the selected bit of the flags byte to `flag_wval` and leaves the other seven bits of that byte unchanged.
- R8: When a byte write to index 1 or a pair write to pair 0 occurs in the same cycle as a flag update, the flag update is dropped and the flags byte takes the byte or pair data. A flag update alongside a write to any other register still applies.
- R9: A stack pointer write lands on the next edge and reads back unchanged on `sp_q`.
- R10: With no program counter load, `pc_adv` values 1, 2 and 3 add that amount to the program counter modulo 2^16. A value of 0 holds it.
- R11: A program counter load (`pc_we`) in the same cycle as a nonzero advance wins: the program counter becomes `pc_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| byte_we | input | 1 | Byte write enable |
| byte_wsel | input | 3 | Byte register written |
| byte_wdata | input | 8 | Byte write data |
| pair_we | input | 1 | Pair write enable |
| pair_wsel | input | 2 | Pair written |
| pair_wdata | input | 16 | Pair write data, high byte in bits 15:8 |
| byte_rsel | input | 3 | Byte register read |
| byte_rdata | output | 8 | Byte read data, combinational |
| pair_rsel | input | 2 | Pair read |
| pair_rdata | output | 16 | Pair read data, combinational |
| flag_we | input | 1 | Single-flag update enable |
| flag_wsel | input | 2 | Flag updated |
| flag_wval | input | 1 | New flag value |
| flag_rsel | input | 2 | Flag read |
| flag_rval | output | 1 | Selected flag value, combinational |
| sp_we | input | 1 | Stack pointer write enable |
| sp_wdata | input | 16 | Stack pointer write data |
| sp_q | output | 16 | Stack pointer |
| pc_we | input | 1 | Program counter load enable |
| pc_wdata | input | 16 | Program counter load value |
| pc_adv | input | 2 | Instruction length to add (0 = none) |
| pc_q | output | 16 | Program counter |

## Verification
Every write-type stimulus, whether a byte, pair, flag, stack pointer or program counter change, takes effect at exactly one rising edge. Its result is due in the first read after that edge. The bench applies inputs on a falling edge and clears the enables on the next falling edge. It compares the combinational reads a nanosecond later, so exactly one edge separates cause and observation. For the write-visibility part of R2, the bench instead samples the read port before that edge and expects the old value. The flags byte is swept over all 256 values for flag reads and over sixteen patterns for every single-flag update, and the program counter is swept across wrap-around with every advance length.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int NUM_BYTE_REGS = 8;
  localparam int NUM_PAIRS     = NUM_BYTE_REGS / 2;
  localparam int BSEL_W        = $clog2(NUM_BYTE_REGS);
  localparam int PSEL_W        = BSEL_W - 1;
  localparam int FSEL_W        = 2;
  localparam int ADV_W         = 2;
  localparam int FLAG_REG_IDX  = 1;

  typedef enum logic [BSEL_W-1:0] {
    R_ACC = 3'd0, R_FLG = 3'd1, R_G0H = 3'd2, R_G0L = 3'd3,
    R_G1H = 3'd4, R_G1L = 3'd5, R_G2H = 3'd6, R_G2L = 3'd7
  } byte_reg_e;

  typedef enum logic [FSEL_W-1:0] {
    F_ZERO = 2'd0, F_SUB = 2'd1, F_HALF = 2'd2, F_CARRY = 2'd3
  } flag_e;
endpackage

// File: rtl/rf_byte_bank.sv
module rf_byte_bank
  import regfile_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  byte_we,
  input  logic [BSEL_W-1:0]                     byte_wsel,
  input  logic [BYTE_W-1:0]                     byte_wdata,
  input  logic                                  pair_we,
  input  logic [PSEL_W-1:0]                     pair_wsel,
  input  logic [2*BYTE_W-1:0]                   pair_wdata,
  input  logic                                  flag_we,
  input  logic [FSEL_W-1:0]                     flag_wsel,
  input  logic                                  flag_wval,
  output logic [NUM_BYTE_REGS-1:0][BYTE_W-1:0]  regs_q
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BIT_W-1:0]  flag_pos;
  logic [BYTE_W-1:0] flag_mask;
  logic              flag_claimed;

  assign flag_pos  = BIT_W'(BYTE_W - 1) - BIT_W'(flag_wsel);
  assign flag_mask = BYTE_W'(1) << flag_pos;
  assign flag_claimed = (byte_we && (byte_wsel == BSEL_W'(FLAG_REG_IDX))) ||
                        (pair_we && (pair_wsel == PSEL_W'(FLAG_REG_IDX / 2)));

  for (genvar gi = 0; gi < NUM_BYTE_REGS; gi++) begin : g_reg
    localparam int  PAIR_IDX = gi / 2;
    localparam bit  IS_HIGH  = (gi % 2) == 0;

    logic              hit_byte;
    logic              hit_pair;
    logic [BYTE_W-1:0] pair_half;
    logic [BYTE_W-1:0] nxt;
    logic [BYTE_W-1:0] q;

    assign hit_byte  = byte_we && (byte_wsel == BSEL_W'(gi));
    assign hit_pair  = pair_we && (pair_wsel == PSEL_W'(PAIR_IDX));
    assign pair_half = IS_HIGH ? pair_wdata[2*BYTE_W-1:BYTE_W]
                               : pair_wdata[BYTE_W-1:0];

    if (gi == FLAG_REG_IDX) begin : g_flags
      always_comb begin
        nxt = q;
        if (hit_byte)      nxt = byte_wdata;
        else if (hit_pair) nxt = pair_half;
        else if (flag_we)  nxt = (q & ~flag_mask) | (flag_wval ? flag_mask : '0);
      end
    end else begin : g_plain
      always_comb begin
        nxt = q;
        if (hit_byte)      nxt = byte_wdata;
        else if (hit_pair) nxt = pair_half;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
    end

    assign regs_q[gi] = q;
  end

  // R2
  byte_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    byte_we |=> regs_q[$past(byte_wsel)] == $past(byte_wdata));

  // R4
  pair_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_we && !(byte_we && (byte_wsel[BSEL_W-1:1] == pair_wsel)))
    |=> {regs_q[{$past(pair_wsel), 1'b0}], regs_q[{$past(pair_wsel), 1'b1}]} == $past(pair_wdata));

  // R7
  flag_others_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !flag_claimed)
    |=> ((regs_q[FLAG_REG_IDX] ^ $past(regs_q[FLAG_REG_IDX])) & ~$past(flag_mask)) == '0);

  // R7
  flag_bit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_we && !flag_claimed)
    |=> regs_q[FLAG_REG_IDX][$past(flag_pos)] == $past(flag_wval));
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [NUM_BYTE_REGS-1:0][BYTE_W-1:0] regs_q,
  input  logic [BSEL_W-1:0]                    byte_rsel,
  output logic [BYTE_W-1:0]                    byte_rdata,
  input  logic [PSEL_W-1:0]                    pair_rsel,
  output logic [2*BYTE_W-1:0]                  pair_rdata,
  input  logic [FSEL_W-1:0]                    flag_rsel,
  output logic                                 flag_rval
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [BIT_W-1:0]  rd_pos;
  logic [BYTE_W-1:0] flags_byte;

  assign byte_rdata = regs_q[byte_rsel];
  assign pair_rdata = {regs_q[{pair_rsel, 1'b0}], regs_q[{pair_rsel, 1'b1}]};
  assign flags_byte = regs_q[FLAG_REG_IDX];
  assign rd_pos     = BIT_W'(BYTE_W - 1) - BIT_W'(flag_rsel);
  assign flag_rval  = flags_byte[rd_pos];
endmodule

// File: rtl/rf_pointer_regs.sv
module rf_pointer_regs
  import regfile_pkg::*;
#(
  parameter int          WORD_W   = 16,
  parameter int unsigned PC_RESET = 'h0100,
  parameter int unsigned SP_RESET = 'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sp_we,
  input  logic [WORD_W-1:0] sp_wdata,
  output logic [WORD_W-1:0] sp_q,
  input  logic              pc_we,
  input  logic [WORD_W-1:0] pc_wdata,
  input  logic [ADV_W-1:0]  pc_adv,
  output logic [WORD_W-1:0] pc_q
);
  logic [WORD_W-1:0] pc_nxt;

  always_comb begin
    if (pc_we) pc_nxt = pc_wdata;
    else       pc_nxt = pc_q + WORD_W'(pc_adv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= WORD_W'(PC_RESET);
      sp_q <= WORD_W'(SP_RESET);
    end else begin
      pc_q <= pc_nxt;
      if (sp_we) sp_q <= sp_wdata;
    end
  end

  // R9
  sp_write_chk: assert property (@(posedge clk) disable iff (rst)
    sp_we |=> sp_q == $past(sp_wdata));

  // R11
  pc_load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> pc_q == $past(pc_wdata));

  // R10
  pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && pc_adv != '0) |=> pc_q == WORD_W'($past(pc_q) + WORD_W'($past(pc_adv))));

  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pc_we && pc_adv == '0) |=> $stable(pc_q));
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import regfile_pkg::*;
#(
  parameter int          BYTE_W   = 8,
  parameter int unsigned PC_RESET = 'h0100,
  parameter int unsigned SP_RESET = 'h0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_we,
  input  logic [2:0]          byte_wsel,
  input  logic [BYTE_W-1:0]   byte_wdata,
  input  logic                pair_we,
  input  logic [1:0]          pair_wsel,
  input  logic [2*BYTE_W-1:0] pair_wdata,
  input  logic [2:0]          byte_rsel,
  output logic [BYTE_W-1:0]   byte_rdata,
  input  logic [1:0]          pair_rsel,
  output logic [2*BYTE_W-1:0] pair_rdata,
  input  logic                flag_we,
  input  logic [1:0]          flag_wsel,
  input  logic                flag_wval,
  input  logic [1:0]          flag_rsel,
  output logic                flag_rval,
  input  logic                sp_we,
  input  logic [2*BYTE_W-1:0] sp_wdata,
  output logic [2*BYTE_W-1:0] sp_q,
  input  logic                pc_we,
  input  logic [2*BYTE_W-1:0] pc_wdata,
  input  logic [1:0]          pc_adv,
  output logic [2*BYTE_W-1:0] pc_q
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [NUM_BYTE_REGS-1:0][BYTE_W-1:0] regs_q;

  rf_byte_bank #(.BYTE_W(BYTE_W)) i_bank (
    .clk        (clk),
    .rst        (rst),
    .byte_we    (byte_we),
    .byte_wsel  (byte_wsel),
    .byte_wdata (byte_wdata),
    .pair_we    (pair_we),
    .pair_wsel  (pair_wsel),
    .pair_wdata (pair_wdata),
    .flag_we    (flag_we),
    .flag_wsel  (flag_wsel),
    .flag_wval  (flag_wval),
    .regs_q     (regs_q)
  );

  rf_read_port #(.BYTE_W(BYTE_W)) i_read (
    .regs_q     (regs_q),
    .byte_rsel  (byte_rsel),
    .byte_rdata (byte_rdata),
    .pair_rsel  (pair_rsel),
    .pair_rdata (pair_rdata),
    .flag_rsel  (flag_rsel),
    .flag_rval  (flag_rval)
  );

  rf_pointer_regs #(
    .WORD_W   (WORD_W),
    .PC_RESET (PC_RESET),
    .SP_RESET (SP_RESET)
  ) i_ptr (
    .clk      (clk),
    .rst      (rst),
    .sp_we    (sp_we),
    .sp_wdata (sp_wdata),
    .sp_q     (sp_q),
    .pc_we    (pc_we),
    .pc_wdata (pc_wdata),
    .pc_adv   (pc_adv),
    .pc_q     (pc_q)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_q == WORD_W'(PC_RESET)) && (sp_q == WORD_W'(SP_RESET)) && (regs_q == '0));
endmodule

// File: tb/test_cpu_regfile.sv
`timescale 1ns/1ps
module test_cpu_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_we = 0;
  logic [2:0]  byte_wsel = 0;
  logic [7:0]  byte_wdata = 0;
  logic        pair_we = 0;
  logic [1:0]  pair_wsel = 0;
  logic [15:0] pair_wdata = 0;
  logic [2:0]  byte_rsel = 0;
  logic [7:0]  byte_rdata;
  logic [1:0]  pair_rsel = 0;
  logic [15:0] pair_rdata;
  logic        flag_we = 0;
  logic [1:0]  flag_wsel = 0;
  logic        flag_wval = 0;
  logic [1:0]  flag_rsel = 0;
  logic        flag_rval;
  logic        sp_we = 0;
  logic [15:0] sp_wdata = 0;
  logic [15:0] sp_q;
  logic        pc_we = 0;
  logic [15:0] pc_wdata = 0;
  logic [1:0]  pc_adv = 0;
  logic [15:0] pc_q;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0]  m_b [8];
  logic [15:0] m_sp;
  logic [15:0] m_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_regfile i_cpu_regfile (
    .clk(clk), .rst(rst),
    .byte_we(byte_we), .byte_wsel(byte_wsel), .byte_wdata(byte_wdata),
    .pair_we(pair_we), .pair_wsel(pair_wsel), .pair_wdata(pair_wdata),
    .byte_rsel(byte_rsel), .byte_rdata(byte_rdata),
    .pair_rsel(pair_rsel), .pair_rdata(pair_rdata),
    .flag_we(flag_we), .flag_wsel(flag_wsel), .flag_wval(flag_wval),
    .flag_rsel(flag_rsel), .flag_rval(flag_rval),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_q(sp_q),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_adv(pc_adv), .pc_q(pc_q)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    byte_we = 0; pair_we = 0; flag_we = 0; sp_we = 0; pc_we = 0; pc_adv = 0;
  endtask

  // one rising edge passes; returns on a falling edge with enables cleared
  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      byte_rsel = 3'(i); #1;
      chk({tag, " byte"}, {8'h00, byte_rdata}, {8'h00, m_b[i]});
    end
    for (int p = 0; p < 4; p++) begin
      pair_rsel = 2'(p); #1;
      chk({"R3 ", tag, " pair"}, pair_rdata, {m_b[2*p], m_b[2*p+1]});
    end
    chk({tag, " sp"}, sp_q, m_sp);
    chk({tag, " pc"}, pc_q, m_pc);
    @(negedge clk);
  endtask

  function automatic logic [7:0] put_flag(input logic [7:0] f, input int sel, input logic v);
    logic [7:0] r;
    r = f;
    r[7 - sel] = v;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_b[i] = 8'h00;
    m_sp = 16'h0000;
    m_pc = 16'h0100;
    repeat (3) @(negedge clk);
    rst = 0;
    check_all("R1");

    // R2: not visible before the edge, visible after
    byte_we = 1; byte_wsel = 3'd0; byte_wdata = 8'h3C;
    byte_rsel = 3'd0; #1;
    chk("R2 before edge", {8'h00, byte_rdata}, 16'h0000);
    @(negedge clk); clear_in();
    m_b[0] = 8'h3C;
    #1; chk("R2 after edge", {8'h00, byte_rdata}, 16'h003C);
    @(negedge clk);

    // R2: every byte register
    for (int i = 0; i < 8; i++) begin
      byte_we = 1; byte_wsel = 3'(i); byte_wdata = 8'(i * 37 + 11);
      m_b[i] = 8'(i * 37 + 11);
      step();
    end
    check_all("R2");

    // R3: example from the requirement
    byte_we = 1; byte_wsel = 3'd0; byte_wdata = 8'h55; step();
    byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'hFF; step();
    m_b[0] = 8'h55; m_b[1] = 8'hFF;
    pair_rsel = 2'd0; #1;
    chk("R3 acc/flags pair", pair_rdata, 16'h55FF);
    @(negedge clk);

    // R4: pair writes
    for (int p = 0; p < 4; p++) begin
      pair_we = 1; pair_wsel = 2'(p); pair_wdata = 16'hA5C3 + 16'(p * 16'h1111);
      m_b[2*p]   = pair_wdata[15:8];
      m_b[2*p+1] = pair_wdata[7:0];
      step();
    end
    check_all("R4");

    // R5: collisions
    pair_we = 1; pair_wsel = 2'd1; pair_wdata = 16'h1234;
    byte_we = 1; byte_wsel = 3'd3; byte_wdata = 8'h77;
    m_b[2] = 8'h12; m_b[3] = 8'h77;
    step();
    pair_we = 1; pair_wsel = 2'd3; pair_wdata = 16'hBEEF;
    byte_we = 1; byte_wsel = 3'd6; byte_wdata = 8'h09;
    m_b[6] = 8'h09; m_b[7] = 8'hEF;
    step();
    check_all("R5");

    // R6: every flags byte value, every flag select
    for (int v = 0; v < 256; v++) begin
      byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'(v);
      step();
      for (int s = 0; s < 4; s++) begin
        flag_rsel = 2'(s); #1;
        chk("R6 flag read", {15'h0, flag_rval}, {15'h0, 1'(v >> (7 - s))});
      end
      @(negedge clk);
    end
    m_b[1] = 8'hFF;

    // R7: single-flag updates over sixteen patterns
    for (int b = 0; b < 16; b++) begin
      for (int s = 0; s < 4; s++) begin
        for (int v = 0; v < 2; v++) begin
          byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'(b * 17);
          step();
          flag_we = 1; flag_wsel = 2'(s); flag_wval = 1'(v);
          step();
          byte_rsel = 3'd1; #1;
          chk("R7 flag update", {8'h00, byte_rdata},
              {8'h00, put_flag(8'(b * 17), s, 1'(v))});
          @(negedge clk);
        end
      end
    end
    m_b[1] = put_flag(8'hFF, 3, 1'b1);
    check_all("R7");

    // R8: flag update dropped against byte write to flags
    byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'hF0; step();
    byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'h00;
    flag_we = 1; flag_wsel = 2'd0; flag_wval = 1'b1;
    step();
    byte_rsel = 3'd1; #1;
    chk("R8 byte beats flag", {8'h00, byte_rdata}, 16'h0000);
    @(negedge clk);
    // dropped against pair write to pair 0
    pair_we = 1; pair_wsel = 2'd0; pair_wdata = 16'h1200;
    flag_we = 1; flag_wsel = 2'd3; flag_wval = 1'b1;
    step();
    pair_rsel = 2'd0; #1;
    chk("R8 pair beats flag", pair_rdata, 16'h1200);
    @(negedge clk);
    // applied alongside a write elsewhere
    byte_we = 1; byte_wsel = 3'd0; byte_wdata = 8'h9A;
    flag_we = 1; flag_wsel = 2'd2; flag_wval = 1'b1;
    step();
    m_b[0] = 8'h9A; m_b[1] = 8'h20;
    check_all("R8");

    // R9: stack pointer
    for (int k = 0; k < 4; k++) begin
      sp_we = 1; sp_wdata = 16'hF1F1 ^ 16'(k * 16'h1357);
      m_sp = sp_wdata;
      step();
      #1; chk("R9 sp", sp_q, m_sp);
      @(negedge clk);
    end

    // R10: advances from reset value
    pc_adv = 2'd1; step(); m_pc = 16'h0101;
    #1; chk("R10 adv1", pc_q, m_pc); @(negedge clk);
    pc_adv = 2'd2; step(); m_pc = 16'h0103;
    #1; chk("R10 adv2", pc_q, m_pc); @(negedge clk);
    pc_adv = 2'd3; step(); m_pc = 16'h0106;
    #1; chk("R10 adv3", pc_q, m_pc); @(negedge clk);
    step();
    #1; chk("R10 hold", pc_q, m_pc); @(negedge clk);

    // R11: load beats advance
    pc_we = 1; pc_wdata = 16'hFFFE; pc_adv = 2'd3; step(); m_pc = 16'hFFFE;
    #1; chk("R11 load wins", pc_q, m_pc); @(negedge clk);
    pc_adv = 2'd3; step(); m_pc = 16'h0001;
    #1; chk("R10 wrap", pc_q, m_pc); @(negedge clk);

    // R10: sweep near the wrap point with every length
    for (int st = 0; st < 8; st++) begin
      for (int a = 0; a < 4; a++) begin
        pc_we = 1; pc_wdata = 16'hFFF8 + 16'(st); step();
        pc_adv = 2'(a); step();
        #1; chk("R10 sweep", pc_q, 16'(16'hFFF8 + 16'(st) + 16'(a)));
        @(negedge clk);
      end
    end
    m_pc = pc_q;
    check_all("R10");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule